// File: doc/BRIEF.md
# Conversion Sequencer with Host Wait Insertion

This block times one sample of a sampling converter whose clock runs in step with the host processor's clock. The host requests a sample with a convert-start pulse. The pulse is taken only if it stays high for a minimum number of consecutive cycles while the sequencer is ready. Once the pulse is taken, the track/hold is switched to hold. The hold switch needs a short settling window. Any host bus access made in that window is held off with a wait signal.

A fixed-length conversion count follows. The count stops advancing in any cycle in which the host drives the bus, so each access made during a conversion adds one cycle to it. At the end of the conversion the track/hold returns to track. A one-cycle done strobe and a sample-write strobe are issued, carrying the result bits that a stub comparator presents on `result_in`. An acquisition period then runs before the sequencer is ready again. A start request seen during the done cycle or the acquisition period is ignored and sets a sticky error flag. Separate read and write strobes are derived from an address strobe and a read/write direction line.

States:
- `SQ_READY`: track, waiting for start.
- `SQ_SETTLE`: track-to-hold window.
- `SQ_CONVERT`: conversion count.
- `SQ_DONE`: one cycle, strobes out.
- `SQ_ACQUIRE`: acquisition count.

Transitions:
- READY→SETTLE on an accepted start.
- SETTLE→CONVERT when the settle count ends.
- CONVERT→DONE when the conversion count ends in a cycle with no bus access.
- DONE→ACQUIRE always.
- ACQUIRE→READY when the acquisition count ends.

Top module: `conv_seq`

## Requirements
- R1: After reset the sequencer is ready: `th_hold`, `busy`, `host_wait`, `conv_done`, `sample_wr` and `start_err` are all 0.
- R2: While ready, `cnv_start` is accepted at the clock edge where it has been high for START_MIN_W consecutive cycles. A shorter high run changes no output.
- R3: `th_hold` is 1 from the cycle after acceptance through the settle window and the conversion. `busy` is 1 from the cycle after acceptance until the sequencer is ready again.
- R4: The settle window lasts SETTLE_CYCLES cycles. `host_wait` is 1 exactly in those settle cycles in which `bus_as` is 1, and is 0 in every other cycle.
- R5: The conversion lasts CONV_CYCLES cycles plus one cycle for each conversion cycle in which `bus_as` is 1.
- R6: In the cycle after the conversion ends, `conv_done` and `sample_wr` are 1 for exactly one cycle. `sample_data` then equals `result_in` as sampled at the last conversion edge.
- R7: The done cycle is followed by ACQ_CYCLES cycles of acquisition before the sequencer is ready again.
- R8: `cnv_start` high during the done cycle or the acquisition period does not start a conversion and does not shorten acquisition. It sets `start_err`, which stays 1 until reset.
- R9: `rd_stb` is `bus_as` AND `bus_rnw`, and `wr_stb` is `bus_as` AND NOT `bus_rnw` (`bus_rnw` = 1 means read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, in step with the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_start | input | 1 | Convert-start request, active high |
| bus_as | input | 1 | Host address strobe, active high |
| bus_rnw | input | 1 | Host direction, 1 = read, 0 = write |
| result_in | input | DATA_W | Result bits from the comparator stub |
| th_hold | output | 1 | 1 = track/hold in hold |
| busy | output | 1 | Sequencer not ready for a new start |
| host_wait | output | 1 | Wait request toward the host |
| rd_stb | output | 1 | Derived read strobe |
| wr_stb | output | 1 | Derived write strobe |
| conv_done | output | 1 | One-cycle end-of-conversion strobe |
| sample_wr | output | 1 | One-cycle write strobe toward the sample buffer |
| sample_data | output | DATA_W | Captured result |
| start_err | output | 1 | Sticky flag for a start seen too early |

## Verification
The embedded assertions check the following every cycle:
- a wait request only ever appears while the track/hold is holding;
- the done strobe never lasts two cycles;
- the error flag never clears;
- the two bus strobes are exclusive;
- a conversion never ends in a cycle with a bus access;
- a start is never accepted on a single high cycle.

Only the bench scenarios can show the exact lengths of the windows. These cover:
- how many accesses stretch a given conversion;
- the cycle at which a result is captured;
- that early starts neither restart nor shorten acquisition.

The bench shows this by comparing every output against a behavioural model on every clock.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [2:0] {
        SQ_READY,
        SQ_SETTLE,
        SQ_CONVERT,
        SQ_DONE,
        SQ_ACQUIRE
    } seq_state_t;
endpackage

// File: rtl/conv_seq_busdec.sv
module conv_seq_busdec (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_as,
    input  logic bus_rnw,
    output logic rd_stb,
    output logic wr_stb
);
    always_comb begin
        rd_stb = bus_as & bus_rnw;
        wr_stb = bus_as & ~bus_rnw;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb)); // R9
    AST_WR_NEEDS_AS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> bus_as); // R9
endmodule

// File: rtl/conv_seq_startq.sv
module conv_seq_startq #(
    parameter int START_MIN_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic start_i,
    output logic start_ok
);
    localparam int WW = $clog2(START_MIN_W + 1);

    logic [WW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= '0;
        else if (!arm || !start_i)
            run_q <= '0;
        else if (run_q != WW'(START_MIN_W))
            run_q <= run_q + 1'b1;
    end

    always_comb
        start_ok = arm && start_i && (run_q >= WW'(START_MIN_W - 1));

    generate
        if (START_MIN_W > 1) begin : g_width_chk
            AST_NO_SHORT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
                start_ok |-> (run_q != '0)); // R2
        end
    endgenerate
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int DATA_W        = 12,
    parameter int START_MIN_W   = 2,
    parameter int SETTLE_CYCLES = 4,
    parameter int CONV_CYCLES   = 57,
    parameter int ACQ_CYCLES    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_start,
    input  logic              bus_as,
    input  logic              bus_rnw,
    input  logic [DATA_W-1:0] result_in,
    output logic              th_hold,
    output logic              busy,
    output logic              host_wait,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              conv_done,
    output logic              sample_wr,
    output logic [DATA_W-1:0] sample_data,
    output logic              start_err
);
    localparam int MAX_A   = (SETTLE_CYCLES > CONV_CYCLES) ? SETTLE_CYCLES : CONV_CYCLES;
    localparam int CNT_MAX = (MAX_A > ACQ_CYCLES) ? MAX_A : ACQ_CYCLES;
    localparam int CW      = $clog2(CNT_MAX + 1);

    seq_state_t        st, nxt;
    logic [CW-1:0]     cnt;
    logic              cnt_clr, cnt_inc;
    logic              start_ok;
    logic              err_q;
    logic [DATA_W-1:0] sample_q;

    conv_seq_busdec u_busdec (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_as  (bus_as),
        .bus_rnw (bus_rnw),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb)
    );

    conv_seq_startq #(.START_MIN_W(START_MIN_W)) u_startq (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (st == SQ_READY),
        .start_i  (cnv_start),
        .start_ok (start_ok)
    );

    // next state and counter control
    always_comb begin
        nxt     = st;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (st)
            SQ_READY: begin
                if (start_ok) begin
                    nxt     = SQ_SETTLE;
                    cnt_clr = 1'b1;
                end
            end
            SQ_SETTLE: begin
                if (cnt == CW'(SETTLE_CYCLES - 1)) begin
                    nxt     = SQ_CONVERT;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            SQ_CONVERT: begin
                if (!bus_as) begin
                    if (cnt == CW'(CONV_CYCLES - 1)) begin
                        nxt     = SQ_DONE;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            SQ_DONE: begin
                nxt     = SQ_ACQUIRE;
                cnt_clr = 1'b1;
            end
            SQ_ACQUIRE: begin
                if (cnt == CW'(ACQ_CYCLES - 1)) begin
                    nxt     = SQ_READY;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: begin
                nxt     = SQ_READY;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // state register, counter, capture and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= SQ_READY;
            cnt      <= '0;
            err_q    <= 1'b0;
            sample_q <= '0;
        end else begin
            st <= nxt;
            if (cnt_clr)
                cnt <= '0;
            else if (cnt_inc)
                cnt <= cnt + 1'b1;
            if (st == SQ_CONVERT && nxt == SQ_DONE)
                sample_q <= result_in;
            if ((st == SQ_DONE || st == SQ_ACQUIRE) && cnv_start)
                err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        th_hold   = 1'b0;
        busy      = 1'b1;
        host_wait = 1'b0;
        conv_done = 1'b0;
        unique case (st)
            SQ_READY:   busy = 1'b0;
            SQ_SETTLE: begin
                th_hold   = 1'b1;
                host_wait = bus_as;
            end
            SQ_CONVERT: th_hold = 1'b1;
            SQ_DONE:    conv_done = 1'b1;
            SQ_ACQUIRE: busy = 1'b1;
            default:    busy = 1'b1;
        endcase
        sample_wr   = conv_done;
        sample_data = sample_q;
        start_err   = err_q;
    end

    AST_WAIT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        host_wait |-> th_hold); // R4
    AST_HOLD_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        th_hold |-> busy); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        start_err |=> start_err); // R8
    AST_CONV_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_CONVERT && bus_as) |=> (st == SQ_CONVERT)); // R5
    AST_DONE_TO_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (busy && !th_hold)); // R7
endmodule

// File: tb/conv_seq_test.sv
module conv_seq_test;
    localparam int DW   = 12;
    localparam int MINW = 2;
    localparam int SETC = 3;
    localparam int CONC = 10;
    localparam int ACQC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnv_start = 1'b0;
    logic          bus_as = 1'b0;
    logic          bus_rnw = 1'b0;
    logic [DW-1:0] result_in = '0;
    logic          th_hold, busy, host_wait, rd_stb, wr_stb;
    logic          conv_done, sample_wr, start_err;
    logic [DW-1:0] sample_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int tick = 0;

    // behavioural reference: phase 0 ready, 1 settle, 2 convert, 3 done, 4 acquire
    int          ph = 0;
    int          rem = 0;
    int          wid = 0;
    bit          m_err = 0;
    int          m_data = 0;

    always #5 clk = ~clk;

    conv_seq #(
        .DATA_W(DW), .START_MIN_W(MINW), .SETTLE_CYCLES(SETC),
        .CONV_CYCLES(CONC), .ACQ_CYCLES(ACQC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .bus_as(bus_as),
        .bus_rnw(bus_rnw), .result_in(result_in), .th_hold(th_hold), .busy(busy),
        .host_wait(host_wait), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .conv_done(conv_done), .sample_wr(sample_wr), .sample_data(sample_data),
        .start_err(start_err)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; rem = 0; wid = 0; m_err = 0; m_data = 0;
        end else begin
            case (ph)
                0: begin
                    if (cnv_start) begin
                        wid = wid + 1;
                        if (wid >= MINW) begin ph = 1; rem = SETC; wid = 0; end
                    end else wid = 0;
                end
                1: begin
                    rem = rem - 1;
                    if (rem == 0) begin ph = 2; rem = CONC; end
                end
                2: begin
                    if (!bus_as) begin
                        rem = rem - 1;
                        if (rem == 0) begin ph = 3; m_data = int'(result_in); end
                    end
                end
                3: begin
                    if (cnv_start) m_err = 1;
                    ph = 4; rem = ACQC;
                end
                default: begin
                    if (cnv_start) m_err = 1;
                    rem = rem - 1;
                    if (rem == 0) begin ph = 0; wid = 0; end
                end
            endcase
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string busy_req;
        string hold_req;
        busy_req = (ph == 0) ? "R2" : ((ph == 4) ? "R7" : "R3");
        hold_req = (ph == 2) ? "R5" : "R3";
        chk(hold_req, "th_hold", int'(th_hold), (ph == 1 || ph == 2) ? 1 : 0);
        chk(busy_req, "busy", int'(busy), (ph != 0) ? 1 : 0);
        chk("R4", "host_wait", int'(host_wait), (ph == 1 && bus_as) ? 1 : 0);
        chk("R6", "conv_done", int'(conv_done), (ph == 3) ? 1 : 0);
        chk("R6", "sample_wr", int'(sample_wr), (ph == 3) ? 1 : 0);
        if (ph == 3) chk("R6", "sample_data", int'(sample_data), m_data);
        chk("R8", "start_err", int'(start_err), int'(m_err));
        chk("R9", "rd_stb", int'(rd_stb), (bus_as && bus_rnw) ? 1 : 0);
        chk("R9", "wr_stb", int'(wr_stb), (bus_as && !bus_rnw) ? 1 : 0);
    endtask

    task automatic step(input logic s, input logic as, input logic rnw);
        @(negedge clk);
        compare_all();
        tick++;
        cnv_start = s;
        bus_as    = as;
        bus_rnw   = rnw;
        result_in = DW'((tick * 37 + 5) % 4096);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cnv_start = 1'b0; bus_as = 1'b0; bus_rnw = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "th_hold", int'(th_hold), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "host_wait", int'(host_wait), 0);
        chk("R1", "conv_done", int'(conv_done), 0);
        chk("R1", "sample_wr", int'(sample_wr), 0);
        chk("R1", "start_err", int'(start_err), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        idle(4);
        // R2: single-cycle pulse is not accepted
        step(1'b1, 1'b0, 1'b0);
        idle(4);
        chk("R2", "busy after short pulse", int'(busy), 0);
        // plain conversion
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        idle(30);
        // R4/R5: reads in settle, mixed accesses in conversion
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) step(1'b0, (i % 4) == 1 || i < 2, (i % 3) != 0);
        idle(10);
        // writes in settle, long start pulse held into settle/convert
        for (int i = 0; i < 6; i++) step(1'b1, i >= 2, 1'b0);
        idle(30);
        // R8: start during acquisition
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 30; i++) step((i == 16 || i == 17), 1'b0, 1'b1);
        chk("R8", "start_err sticky", int'(start_err), 1);
        idle(20);
        // reset clears the flag
        do_reset();
        idle(3);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule